// File: doc/BRIEF.md
# Delay-Line Exit Slot Scheduler

This block is the controller for a one-stage delay-line buffer in front of a cyclic time-division switch. The switch steps through N connection patterns in a fixed rotation, one pattern per slot. A fixed-size cell that enters on source port `r` during slot `t` and is bound for destination `d` can leave only in a slot whose pattern joins `r` to `d`. That fixes the cell's delay modulo N. The scheduler therefore first computes the base offset. It then tries the same offset extended by whole rotations, and stops at the first candidate whose exit slot is still unclaimed.

The buffer has N*B delay lines with delays 0 to N*B-1 slots. The controller keeps a record of the exit slots already claimed within that horizon. The record shifts by one position every slot, and a newly chosen exit slot is set in it. When every candidate for an arrival is already taken, the block raises a discard instead of a line select. This is the extra discard position of the line selector. At most one arrival is handled per slot, and the decision is combinational within that slot.

Top module: `dl_slot_sched`

## Requirements
- R1: For a valid arrival, the base offset is (dst - src - slot_idx) mod N, where N = `N_PORTS`. Every selected line number is congruent to this offset modulo N, and with no exit slot claimed the selected line equals the offset.
- R2: The candidates are offset + k*N for k = 0 .. `DEPTH`-1. The selected line is the candidate with the smallest k whose exit slot (current slot + line) is not already claimed.
- R3: The candidate at line N*`DEPTH`-1 is never claimed. An arrival whose base offset is N-1 is therefore never discarded.
- R4: For each slot with `arr_valid` high, exactly one of `sel_valid` and `drop` is high. `drop` is high only when all `DEPTH` candidates are claimed. With `arr_valid` low, both outputs are low.
- R5: Selecting line D claims the exit slot D slots ahead. A later arrival whose candidate reaches that same absolute slot must skip it.
- R6: The claim record advances by one slot every clock. A claim expires once its exit slot has passed, so after N*`DEPTH`-1 idle slots every candidate is free again.
- R7: While `rst_n` is low, the claim record is cleared. Idle inputs then give no select and no drop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock, one rising edge per slot |
| rst_n | input | 1 | Active-low synchronous reset |
| arr_valid | input | 1 | A cell arrives in this slot |
| arr_src | input | $clog2(N_PORTS) | Source port of the arriving cell |
| arr_dst | input | $clog2(N_PORTS) | Destination port of the arriving cell |
| slot_idx | input | $clog2(N_PORTS) | Current position of the switch rotation |
| sel_valid | output | 1 | A delay line was chosen for the arrival |
| sel_line | output | $clog2(N_PORTS*DEPTH) | Index of the chosen delay line, equal to its delay in slots |
| drop | output | 1 | No free candidate; route the cell to the discard output |

## Verification
The assertions assume that `slot_idx` advances by exactly one modulo N on every clock after reset. They also assume that source and destination values lie below N, and that the controller is clocked once per slot whether or not a cell arrives. The bench meets these assumptions by deriving `slot_idx` from its own slot counter and by taking port numbers from in-range loops or from a masked shift-register sequence. It predicts every decision with its own model of claimed absolute exit times. This model is separate from the block's shifting record.

// File: rtl/lsd_pkg.sv
package lsd_pkg;

   // width of an index able to address v items, never below one bit
   function automatic int unsigned idx_width(int unsigned v);
      return (v <= 1) ? 1 : $clog2(v);
   endfunction

   function automatic bit is_pow2(int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/lsd_offset.sv
module lsd_offset #(
   parameter int unsigned N_PORTS = 4,
   parameter int unsigned PW      = 2
) (
   input  logic [PW-1:0] src_i,
   input  logic [PW-1:0] dst_i,
   input  logic [PW-1:0] slot_i,
   output logic [PW-1:0] delta_o
);

   generate
      if (lsd_pkg::is_pow2(N_PORTS)) begin : g_wrap
         // modulo is free: natural wrap of the PW-bit difference
         assign delta_o = dst_i - src_i - slot_i;
      end else begin : g_mod
         localparam int unsigned AW = PW + 2;
         logic [AW-1:0] acc;
         assign acc     = {2'b00, dst_i} + AW'(2 * N_PORTS)
                        - {2'b00, src_i} - {2'b00, slot_i};
         assign delta_o = PW'(acc % AW'(N_PORTS));
      end
   endgenerate

endmodule

// File: rtl/lsd_occ.sv
module lsd_occ #(
   parameter int unsigned LINES = 12,
   parameter int unsigned LW    = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mark_i,
   input  logic [LW-1:0]    mark_line_i,
   output logic [LINES-1:0] occ_o
);

   localparam int unsigned OW = LINES - 1;

   // bit j: exit slot j slots ahead of the current one is claimed
   logic [OW-1:0]    occ_q;
   logic [LINES-1:0] mark_vec;
   logic [LINES-1:0] nxt;

   always_comb begin
      mark_vec = '0;
      if (mark_i) mark_vec[mark_line_i] = 1'b1;
   end

   // claim, then age by one slot; a delay-0 claim leaves at once
   assign nxt = ({1'b0, occ_q} | mark_vec) >> 1;

   always_ff @(posedge clk) begin
      if (!rst_n) occ_q <= '0;
      else        occ_q <= nxt[OW-1:0];
   end

   // top position (longest delay) is never claimed by an earlier cell
   assign occ_o = {1'b0, occ_q};

   // R6
   shift_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((~occ_q) & ($past(occ_q) >> 1)) == '0);

   // R5
   one_new_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(occ_q & ~($past(occ_q) >> 1)));

   // R5
   claim_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mark_i && mark_line_i != '0) |=> occ_q[$past(mark_line_i) - 1'b1]);

endmodule

// File: rtl/lsd_pick.sv
module lsd_pick #(
   parameter int unsigned N_PORTS = 4,
   parameter int unsigned DEPTH   = 3,
   parameter int unsigned LINES   = 12,
   parameter int unsigned PW      = 2,
   parameter int unsigned LW      = 4
) (
   input  logic [PW-1:0]    delta_i,
   input  logic [LINES-1:0] occ_i,
   output logic             found_o,
   output logic [LW-1:0]    line_o
);

   logic [LW-1:0]    cand [DEPTH];
   logic [DEPTH-1:0] free;

   generate
      for (genvar k = 0; k < DEPTH; k++) begin : g_cand
         assign cand[k] = LW'(delta_i) + LW'(k * N_PORTS);
         assign free[k] = ~occ_i[cand[k]];
      end
   endgenerate

   // priority to the smallest rotation count
   always_comb begin
      found_o = 1'b0;
      line_o  = cand[0];
      for (int k = DEPTH - 1; k >= 0; k--) begin
         if (free[k]) begin
            found_o = 1'b1;
            line_o  = cand[k];
         end
      end
   end

endmodule

// File: rtl/dl_slot_sched.sv
module dl_slot_sched #(
   parameter int unsigned N_PORTS = 4,
   parameter int unsigned DEPTH   = 3,
   localparam int unsigned PW     = lsd_pkg::idx_width(N_PORTS),
   localparam int unsigned LINES  = N_PORTS * DEPTH,
   localparam int unsigned LW     = lsd_pkg::idx_width(LINES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          arr_valid,
   input  logic [PW-1:0] arr_src,
   input  logic [PW-1:0] arr_dst,
   input  logic [PW-1:0] slot_idx,
   output logic          sel_valid,
   output logic [LW-1:0] sel_line,
   output logic          drop
);

   generate
      if (N_PORTS < 2) begin : g_bad_ports
         $error("dl_slot_sched: N_PORTS must be at least 2");
      end
      if (DEPTH < 1) begin : g_bad_depth
         $error("dl_slot_sched: DEPTH must be at least 1");
      end
   endgenerate

   logic [PW-1:0]    delta;
   logic [LINES-1:0] occ;
   logic             found;
   logic [LW-1:0]    pick_line;

   lsd_offset #(.N_PORTS(N_PORTS), .PW(PW)) offset_i (
      .src_i   (arr_src),
      .dst_i   (arr_dst),
      .slot_i  (slot_idx),
      .delta_o (delta)
   );

   lsd_pick #(.N_PORTS(N_PORTS), .DEPTH(DEPTH), .LINES(LINES),
              .PW(PW), .LW(LW)) pick_i (
      .delta_i (delta),
      .occ_i   (occ),
      .found_o (found),
      .line_o  (pick_line)
   );

   lsd_occ #(.LINES(LINES), .LW(LW)) occ_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .mark_i      (sel_valid),
      .mark_line_i (sel_line),
      .occ_o       (occ)
   );

   assign sel_valid = arr_valid & found;
   assign drop      = arr_valid & ~found;
   assign sel_line  = pick_line;

   // R4
   one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
      arr_valid |-> $onehot({sel_valid, drop}));

   // R4
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !arr_valid |-> (!sel_valid && !drop));

   // R1
   residue_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sel_valid |-> ((int'(sel_line) % int'(N_PORTS)) == int'(delta)));

   // R2
   free_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sel_valid |-> !occ[sel_line]);

   // R3
   last_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (arr_valid && int'(delta) == int'(N_PORTS) - 1) |-> sel_valid);

endmodule

// File: tb/dl_slot_sched_tb_top.sv
`timescale 1ns/1ps
module dl_slot_sched_tb_top;

   localparam int N     = 4;
   localparam int B     = 3;
   localparam int LINES = N * B;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       arr_valid = 1'b0;
   logic [1:0] arr_src = '0;
   logic [1:0] arr_dst = '0;
   logic [1:0] slot_idx = '0;
   logic       sel_valid;
   logic [3:0] sel_line;
   logic       drop;

   int checks = 0;
   int errors = 0;
   int now = 0;
   int drops_seen = 0;
   int last_line = 0;
   bit busy [64];
   bit finished = 1'b0;
   logic [15:0] lfsr = 16'hACE1;

   always #2 clk = ~clk;

   dl_slot_sched #(.N_PORTS(N), .DEPTH(B)) dut_i (
      .clk(clk), .rst_n(rst_n), .arr_valid(arr_valid),
      .arr_src(arr_src), .arr_dst(arr_dst), .slot_idx(slot_idx),
      .sel_valid(sel_valid), .sel_line(sel_line), .drop(drop)
   );

   task automatic chk(string req, int act, int exp, string what);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // one slot: drive, predict from absolute claim times, compare, advance
   task automatic step(bit v, int r, int d, string req);
      int delta;
      int expl;
      bit found;
      @(negedge clk);
      arr_valid = v;
      arr_src   = 2'(r);
      arr_dst   = 2'(d);
      slot_idx  = 2'(now % N);
      #1;
      delta = ((d - r - (now % N)) + 2 * N) % N;
      found = 1'b0;
      expl  = 0;
      if (v) begin
         for (int k = 0; k < B; k++) begin
            if (!found && !busy[(now + delta + k * N) % 64]) begin
               found = 1'b1;
               expl  = delta + k * N;
            end
         end
      end
      chk(req, int'(sel_valid), int'(v && found), "select");
      chk(req, int'(drop), int'(v && !found), "drop");
      if (v && found) begin
         chk(req, int'(sel_line), expl, "line");
         busy[(now + expl) % 64] = 1'b1;
         last_line = int'(sel_line);
      end
      if (drop) drops_seen++;
      @(posedge clk);
      busy[now % 64] = 1'b0;
      now++;
   endtask

   task automatic idle_to(int phase, string req);
      while ((now % N) != phase) step(1'b0, 0, 0, req);
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R7: reset clears everything, idle inputs give nothing
      chk("R7", int'(sel_valid), 0, "select in reset");
      chk("R7", int'(drop), 0, "drop in reset");
      rst_n = 1'b1;

      // R1: exhaustive source/destination/slot sweep on an empty record
      for (int t = 0; t < N; t++) begin
         for (int r = 0; r < N; r++) begin
            for (int d = 0; d < N; d++) begin
               idle_to(t, "R4");
               step(1'b1, r, d, "R1");
               chk("R1", last_line, ((d - r - t) + 2 * N) % N, "empty-record offset");
               repeat (LINES) step(1'b0, 0, 0, "R6");
            end
         end
      end

      // R1: rotation position 3, cell needs position 1 -> offset 2
      idle_to(3, "R4");
      step(1'b1, 0, 1, "R1");
      chk("R1", last_line, 2, "worked example offset");
      repeat (LINES) step(1'b0, 0, 0, "R6");

      // R2/R4: fixed port pair every slot saturates one exit residue
      for (int i = 0; i < 24; i++) step(1'b1, 1, 3, "R4");
      chk("R4", int'(drops_seen > 0), 1, "saturation produces discard");

      // R3: keep saturating with each offset; offset N-1 must still select
      for (int i = 0; i < 16; i++) step(1'b1, i % N, (i / N) % N, "R3");

      // R6: record empties after idle slots
      repeat (LINES) step(1'b0, 0, 0, "R6");
      idle_to(0, "R6");
      step(1'b1, 0, 0, "R6");
      chk("R6", last_line, 0, "fresh record gives k=0");

      // R5/R2: pseudo-random arrival pattern
      for (int i = 0; i < 400; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         step(lfsr[1:0] != 2'b00, int'(lfsr[5:4]), int'(lfsr[9:8]), "R5");
      end

      // R4: idle slots after heavy load stay quiet
      repeat (LINES) step(1'b0, 0, 0, "R4");

      finished = 1'b1;
      summary();
      $finish;
   end

   initial begin
      #(4 * 150000);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual hung expected done");
         summary();
         $finish;
      end
   end

endmodule